// File: doc/BRIEF.md
# Display Controller Initialization Register Loader

This block holds the fifteen byte-wide initialization registers of a character-based raster display controller. It decodes them into the timing and format parameters that the raster counters use. A host writes bytes one after another. Each byte lands in the register chosen by an internal pointer, and the pointer then steps forward. It stops at the last register, so extra writes keep overwriting that register instead of wrapping round. A separate command byte can reset the pointer or load it directly.

Every field is presented already decoded, with its offset and scale applied. This covers the porches, the sync and equalizing widths, rows per screen, characters per row, the blink divisor, scroll lines and the two double-size modes. The raw contents of the eight registers with no field decode here are passed out unchanged. The horizontal front porch is worked out from four other fields and is presented as a signed count. A write to the upper byte of the first screen-start address supplies six address bits. When double size is enabled, the same write also replaces the first double-size mode.

Top module: `vid_init_regs`

## Requirements
- R1: After synchronous reset `rst`, the pointer is 0 and all fifteen registers hold 0. The outputs then read: eq_const=1, hsync_w=2, hbp=-1, vfp=4, vbp=4, rows=1, blink_div=64, cpr=1, hfp=8. Every flag, dbl1, dbl2, scroll, ss1_addr_hi and misc_regs read 0.
- R2: A write with `wr_en` stores `wr_data` into the register at the pointer. The pointer then becomes min(pointer+1, 14), so writes past register 14 keep landing in register 14.
- R3: With `cmd_en`, command byte 8'h00 sets the pointer to 0 and leaves the register contents alone. Command byte 8'h1N loads the pointer with N. Any other byte is ignored. A recognized command in the same cycle as a write decides the next pointer, and the write still uses the old pointer.
- R4: Register 0 bit 7 drives dbl_en. Register 1 bit 7 drives interlace_en, and eq_const = register 1 bits 6:0 plus 1.
- R5: Register 2 bit 7 drives row_table. hsync_w = (bits 6:3)*2+2. hbp = (bits 2:0)*4-1, as a signed value.
- R6: vfp = (register 3 bits 7:5)*4+4 and vbp = (register 3 bits 4:0)*2+4.
- R7: rows = (register 4 bits 6:0)+1. blink_div is 128 when register 4 bit 7 is set and 64 when it is clear. cpr = register 5 + 1.
- R8: Register 14 gives scroll = bits 3:0 and dbl2 = bits 5:4. A write to register 14 also loads dbl1 from bits 7:6.
- R9: A write with `ss1_hi_en` loads ss1_addr_hi from bits 5:0 of the byte. It loads dbl1 from bits 7:6 only while dbl_en reads 1, and then it takes priority over a register-14 write in the same cycle. Otherwise dbl1 is left unchanged.
- R10: misc_regs byte k (bits 8k+7:8k) is register 6+k, for k = 0 to 7.
- R11: A write while the pointer is 15 changes no register, and the pointer becomes 14.
- R12: hfp = 2*eq_const + 3*hsync_w - cpr - hbp, computed from the values those outputs had one cycle earlier.
- R13: Decoded fields show a write from the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register data write strobe |
| wr_data | input | 8 | Register data byte |
| cmd_en | input | 1 | Command strobe |
| cmd_data | input | 8 | Command byte |
| ss1_hi_en | input | 1 | Screen-start-1 upper byte write strobe |
| ss1_hi_data | input | 8 | Screen-start-1 upper byte |
| dbl_en | output | 1 | Double height/width enable |
| interlace_en | output | 1 | Interlace enable |
| eq_const | output | 8 | Equalizing constant, character clocks |
| row_table | output | 1 | Row table mode |
| hsync_w | output | 6 | Horizontal sync width, character clocks |
| hbp | output | 6 | Horizontal back porch, signed |
| vfp | output | 6 | Vertical front porch, lines |
| vbp | output | 7 | Vertical back porch, lines |
| rows | output | 8 | Rows per screen |
| blink_div | output | 8 | Character blink divisor |
| cpr | output | 9 | Characters per row |
| scroll | output | 4 | Scroll line count |
| dbl2 | output | 2 | Double mode 2 |
| dbl1 | output | 2 | Double mode 1 |
| ss1_addr_hi | output | 6 | Screen-start-1 upper address bits |
| hfp | output | 12 | Horizontal front porch, signed |
| misc_regs | output | 64 | Raw registers 6 to 13 |

## Verification
The bench builds the block with its default front-porch width of 12 bits. At that width every combination of field values fits without overflow. This covers the extremes: the most negative porch, with 256 characters per row and a long back porch, and the largest positive one. Directed and random traffic reach pointer saturation, a write at pointer 15, and commands that collide with writes. They also exercise the dbl1 priority between a register-14 write and a screen-start write in the same cycle, with double size both on and off.

// File: rtl/vidinit_pkg.sv
package vidinit_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_IR  = 15;
  localparam int PTR_W   = 4;
  localparam int LAST_IR = NUM_IR - 1;
  localparam int MISC_LO = 6;
  localparam int MISC_N  = 8;
  localparam int FP_W_DEF = 12;

  localparam logic [BYTE_W-1:0] CMD_MRST = 8'h00;
  localparam logic [3:0]        CMD_SETP = 4'h1;

  typedef logic [BYTE_W-1:0] byte_t;

  function automatic logic [7:0] f_eq(input byte_t b);
    return {1'b0, b[6:0]} + 8'd1;
  endfunction

  function automatic logic [5:0] f_hsync(input byte_t b);
    return {1'b0, b[6:3], 1'b0} + 6'd2;
  endfunction

  function automatic logic signed [5:0] f_hbp(input byte_t b);
    return $signed({1'b0, b[2:0], 2'b00}) - 6'sd1;
  endfunction

  function automatic logic [5:0] f_vfp(input byte_t b);
    return {1'b0, b[7:5], 2'b00} + 6'd4;
  endfunction

  function automatic logic [6:0] f_vbp(input byte_t b);
    return {1'b0, b[4:0], 1'b0} + 7'd4;
  endfunction

  function automatic logic [7:0] f_rows(input byte_t b);
    return {1'b0, b[6:0]} + 8'd1;
  endfunction

  function automatic logic [7:0] f_blink(input byte_t b);
    return b[7] ? 8'd128 : 8'd64;
  endfunction

  function automatic logic [8:0] f_cpr(input byte_t b);
    return {1'b0, b} + 9'd1;
  endfunction
endpackage

// File: rtl/vidinit_ptr.sv
module vidinit_ptr
  import vidinit_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             cmd_en,
  input  byte_t            cmd_data,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(LAST_IR);

  logic cmd_mrst, cmd_setp;
  logic [PTR_W-1:0] ptr_inc;

  assign cmd_mrst = cmd_en && (cmd_data == CMD_MRST);
  assign cmd_setp = cmd_en && (cmd_data[7:4] == CMD_SETP);
  assign ptr_inc  = (ptr >= LAST) ? LAST : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)           ptr <= '0;
    else if (cmd_mrst) ptr <= '0;
    else if (cmd_setp) ptr <= cmd_data[PTR_W-1:0];
    else if (wr_en)    ptr <= ptr_inc;
  end
endmodule

// File: rtl/vidinit_bank.sv
module vidinit_bank
  import vidinit_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  byte_t                    wr_data,
  input  logic [PTR_W-1:0]         ptr,
  output logic [NUM_IR*BYTE_W-1:0] raw
);
  for (genvar k = 0; k < NUM_IR; k++) begin : g_ir
    always_ff @(posedge clk) begin
      if (rst)
        raw[k*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en && (ptr == PTR_W'(k)))
        raw[k*BYTE_W +: BYTE_W] <= wr_data;
    end
  end
endmodule

// File: rtl/vidinit_dbl.sv
module vidinit_dbl
  import vidinit_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ir14_wr,
  input  byte_t      wr_data,
  input  logic       dbl_en,
  input  logic       ss1_hi_en,
  input  byte_t      ss1_hi_data,
  output logic [1:0] dbl1,
  output logic [5:0] ss1_addr_hi
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dbl1        <= '0;
      ss1_addr_hi <= '0;
    end else begin
      if (ss1_hi_en && dbl_en) dbl1 <= ss1_hi_data[7:6];
      else if (ir14_wr)        dbl1 <= wr_data[7:6];
      if (ss1_hi_en)           ss1_addr_hi <= ss1_hi_data[5:0];
    end
  end
endmodule

// File: rtl/vidinit_hfp.sv
module vidinit_hfp #(
  parameter int FP_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [7:0]             eq_const,
  input  logic [5:0]             hsync_w,
  input  logic [8:0]             cpr,
  input  logic signed [5:0]      hbp,
  output logic signed [FP_W-1:0] hfp
);
  localparam logic signed [FP_W-1:0] HFP_RST = FP_W'(8);

  logic signed [FP_W-1:0] a, b, c, d, sum;

  assign a   = $signed({{(FP_W-8){1'b0}}, eq_const});
  assign b   = $signed({{(FP_W-6){1'b0}}, hsync_w});
  assign c   = $signed({{(FP_W-9){1'b0}}, cpr});
  assign d   = {{(FP_W-6){hbp[5]}}, hbp};
  assign sum = a + a + b + b + b - c - d;

  always_ff @(posedge clk) begin
    if (rst) hfp <= HFP_RST;
    else     hfp <= sum;
  end
endmodule

// File: rtl/vid_init_regs.sv
module vid_init_regs
  import vidinit_pkg::*;
#(
  parameter int FP_W = FP_W_DEF
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [7:0]             wr_data,
  input  logic                   cmd_en,
  input  logic [7:0]             cmd_data,
  input  logic                   ss1_hi_en,
  input  logic [7:0]             ss1_hi_data,
  output logic                   dbl_en,
  output logic                   interlace_en,
  output logic [7:0]             eq_const,
  output logic                   row_table,
  output logic [5:0]             hsync_w,
  output logic signed [5:0]      hbp,
  output logic [5:0]             vfp,
  output logic [6:0]             vbp,
  output logic [7:0]             rows,
  output logic [7:0]             blink_div,
  output logic [8:0]             cpr,
  output logic [3:0]             scroll,
  output logic [1:0]             dbl2,
  output logic [1:0]             dbl1,
  output logic [5:0]             ss1_addr_hi,
  output logic signed [FP_W-1:0] hfp,
  output logic [63:0]            misc_regs
);
  logic [PTR_W-1:0]         ptr_q;
  logic [NUM_IR*BYTE_W-1:0] raw;
  byte_t ir [NUM_IR];
  logic  ir14_wr;

  vidinit_ptr u_ptr (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .cmd_en(cmd_en), .cmd_data(cmd_data), .ptr(ptr_q)
  );

  vidinit_bank u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_data(wr_data), .ptr(ptr_q), .raw(raw)
  );

  for (genvar k = 0; k < NUM_IR; k++) begin : g_view
    assign ir[k] = raw[k*BYTE_W +: BYTE_W];
  end

  for (genvar m = 0; m < MISC_N; m++) begin : g_misc
    assign misc_regs[m*BYTE_W +: BYTE_W] = ir[MISC_LO+m];
  end

  assign dbl_en       = ir[0][7];
  assign interlace_en = ir[1][7];
  assign eq_const     = f_eq(ir[1]);
  assign row_table    = ir[2][7];
  assign hsync_w      = f_hsync(ir[2]);
  assign hbp          = f_hbp(ir[2]);
  assign vfp          = f_vfp(ir[3]);
  assign vbp          = f_vbp(ir[3]);
  assign rows         = f_rows(ir[4]);
  assign blink_div    = f_blink(ir[4]);
  assign cpr          = f_cpr(ir[5]);
  assign scroll       = ir[LAST_IR][3:0];
  assign dbl2         = ir[LAST_IR][5:4];

  assign ir14_wr = wr_en && (ptr_q == PTR_W'(LAST_IR));

  vidinit_dbl u_dbl (
    .clk(clk), .rst(rst), .ir14_wr(ir14_wr), .wr_data(wr_data),
    .dbl_en(dbl_en), .ss1_hi_en(ss1_hi_en), .ss1_hi_data(ss1_hi_data),
    .dbl1(dbl1), .ss1_addr_hi(ss1_addr_hi)
  );

  vidinit_hfp #(.FP_W(FP_W)) u_hfp (
    .clk(clk), .rst(rst), .eq_const(eq_const), .hsync_w(hsync_w),
    .cpr(cpr), .hbp(hbp), .hfp(hfp)
  );
endmodule

// File: rtl/vidinit_chk.sv
module vidinit_chk #(
  parameter int FP_W = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic                   cmd_en,
  input logic [7:0]             cmd_data,
  input logic                   ss1_hi_en,
  input logic [3:0]             ptr,
  input logic                   dbl_en,
  input logic [7:0]             eq_const,
  input logic [5:0]             hsync_w,
  input logic signed [5:0]      hbp,
  input logic [8:0]             cpr,
  input logic [7:0]             blink_div,
  input logic [3:0]             scroll,
  input logic [1:0]             dbl1,
  input logic signed [FP_W-1:0] hfp,
  input logic [63:0]            misc_regs
);
  logic cmd_hit;
  assign cmd_hit = cmd_en && (cmd_data == 8'h00 || cmd_data[7:4] == 4'h1);

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !cmd_hit && ptr < 4'd14) |=> ptr == $past(ptr) + 4'd1); // R2

  AST_PTR_SAT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !cmd_hit && ptr >= 4'd14) |=> ptr == 4'd14); // R2

  AST_MRST_PTR: assert property (@(posedge clk) disable iff (rst)
    (cmd_en && cmd_data == 8'h00) |=> ptr == 4'd0); // R3

  AST_SETP_PTR: assert property (@(posedge clk) disable iff (rst)
    (cmd_en && cmd_data[7:4] == 4'h1) |=> ptr == $past(cmd_data[3:0])); // R3

  AST_IR15_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ptr == 4'd15) |=> ($stable(misc_regs) && $stable(scroll) && $stable(eq_const) && $stable(cpr))); // R11

  AST_DBL1_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ss1_hi_en && !dbl_en && !(wr_en && ptr == 4'd14)) |=> $stable(dbl1)); // R9

  AST_BLINK_LEGAL: assert property (@(posedge clk) disable iff (rst)
    $onehot(blink_div) && (blink_div[7] || blink_div[6])); // R7

  AST_HFP_FORMULA: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (int'(hfp) == 2*int'($past(eq_const)) + 3*int'($past(hsync_w))
                         - int'($past(cpr)) - int'($past(hbp)))); // R12
endmodule

bind vid_init_regs vidinit_chk #(.FP_W(FP_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .cmd_en(cmd_en), .cmd_data(cmd_data),
  .ss1_hi_en(ss1_hi_en), .ptr(ptr_q), .dbl_en(dbl_en), .eq_const(eq_const),
  .hsync_w(hsync_w), .hbp(hbp), .cpr(cpr), .blink_div(blink_div),
  .scroll(scroll), .dbl1(dbl1), .hfp(hfp), .misc_regs(misc_regs)
);

// File: tb/tb_vid_init_regs.sv
`timescale 1ns/1ps
module tb_vid_init_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, cmd_en = 1'b0, ss1_hi_en = 1'b0;
  logic [7:0] wr_data = '0, cmd_data = '0, ss1_hi_data = '0;

  logic dbl_en, interlace_en, row_table;
  logic [7:0] eq_const, rows, blink_div;
  logic [5:0] hsync_w, vfp, ss1_addr_hi;
  logic signed [5:0] hbp;
  logic [6:0] vbp;
  logic [8:0] cpr;
  logic [3:0] scroll;
  logic [1:0] dbl2, dbl1;
  logic signed [11:0] hfp;
  logic [63:0] misc_regs;

  int errors = 0, checks = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  vid_init_regs dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_en(cmd_en), .cmd_data(cmd_data), .ss1_hi_en(ss1_hi_en),
    .ss1_hi_data(ss1_hi_data), .dbl_en(dbl_en), .interlace_en(interlace_en),
    .eq_const(eq_const), .row_table(row_table), .hsync_w(hsync_w), .hbp(hbp),
    .vfp(vfp), .vbp(vbp), .rows(rows), .blink_div(blink_div), .cpr(cpr),
    .scroll(scroll), .dbl2(dbl2), .dbl1(dbl1), .ss1_addr_hi(ss1_addr_hi),
    .hfp(hfp), .misc_regs(misc_regs)
  );

  task automatic chk(input string tag, input string nm, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, nm, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_ir [15];
  int m_ptr, m_dbl1, m_ss1, m_hfp;

  function automatic int e_eq();    return (m_ir[1] & 127) + 1;              endfunction
  function automatic int e_hs();    return ((m_ir[2] >> 3) & 15) * 2 + 2;    endfunction
  function automatic int e_hbp();   return (m_ir[2] & 7) * 4 - 1;            endfunction
  function automatic int e_cpr();   return m_ir[5] + 1;                      endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_ir[i]) m_ir[i] = 0;
      m_ptr = 0; m_dbl1 = 0; m_ss1 = 0; m_hfp = 8;
    end else begin
      int old_ptr;
      bit old_dbl;
      old_ptr = m_ptr;
      old_dbl = m_ir[0][7];
      m_hfp = 2*e_eq() + 3*e_hs() - e_cpr() - e_hbp();
      if (wr_en && old_ptr < 15) m_ir[old_ptr] = int'(wr_data);
      if (wr_en && old_ptr == 14) m_dbl1 = int'(wr_data[7:6]);
      if (ss1_hi_en) begin
        m_ss1 = int'(ss1_hi_data[5:0]);
        if (old_dbl) m_dbl1 = int'(ss1_hi_data[7:6]);
      end
      if (cmd_en && cmd_data == 8'h00) m_ptr = 0;
      else if (cmd_en && cmd_data[7:4] == 4'h1) m_ptr = int'(cmd_data[3:0]);
      else if (wr_en) m_ptr = (old_ptr >= 14) ? 14 : old_ptr + 1;
    end
    started = 1;
  end

  // Compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk("R4", "dbl_en", int'(dbl_en), (m_ir[0] >> 7) & 1);
      chk("R4", "interlace_en", int'(interlace_en), (m_ir[1] >> 7) & 1);
      chk("R4", "eq_const", int'(eq_const), e_eq());
      chk("R5", "row_table", int'(row_table), (m_ir[2] >> 7) & 1);
      chk("R5", "hsync_w", int'(hsync_w), e_hs());
      chk("R5", "hbp", int'(hbp), e_hbp());
      chk("R6", "vfp", int'(vfp), ((m_ir[3] >> 5) & 7) * 4 + 4);
      chk("R6", "vbp", int'(vbp), (m_ir[3] & 31) * 2 + 4);
      chk("R7", "rows", int'(rows), (m_ir[4] & 127) + 1);
      chk("R7", "blink_div", int'(blink_div), m_ir[4][7] ? 128 : 64);
      chk("R7", "cpr", int'(cpr), e_cpr());
      chk("R8", "scroll", int'(scroll), m_ir[14] & 15);
      chk("R8", "dbl2", int'(dbl2), (m_ir[14] >> 4) & 3);
      chk("R9", "dbl1", int'(dbl1), m_dbl1);
      chk("R9", "ss1_addr_hi", int'(ss1_addr_hi), m_ss1);
      chk("R12", "hfp", int'(hfp), m_hfp);
      for (int k = 0; k < 8; k++)
        chk("R10", "misc_regs", int'(misc_regs[k*8 +: 8]), m_ir[6+k]);
    end
  end

  task automatic drv(input bit w, input logic [7:0] wd, input bit c,
                     input logic [7:0] cd, input bit s, input logic [7:0] sd);
    wr_en = w; wr_data = wd; cmd_en = c; cmd_data = cd;
    ss1_hi_en = s; ss1_hi_data = sd;
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] d);  drv(1, d, 0, 8'h00, 0, 8'h00); endtask
  task automatic cmd(input logic [7:0] d); drv(0, 8'h00, 1, d, 0, 8'h00); endtask
  task automatic idle();                   drv(0, 8'h00, 0, 8'h00, 0, 8'h00); endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] bytes [15];
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset values
    chk("R1", "eq_const", int'(eq_const), 1);
    chk("R1", "hsync_w", int'(hsync_w), 2);
    chk("R1", "hbp", int'(hbp), -1);
    chk("R1", "vfp", int'(vfp), 4);
    chk("R1", "vbp", int'(vbp), 4);
    chk("R1", "rows", int'(rows), 1);
    chk("R1", "blink_div", int'(blink_div), 64);
    chk("R1", "cpr", int'(cpr), 1);
    chk("R1", "hfp", int'(hfp), 8);
    chk("R1", "misc_regs", int'(misc_regs[7:0]), 0);

    bytes = '{8'h00, 8'h8A, 8'h5B, 8'hA9, 8'hB1, 8'h4F, 8'h66, 8'h67,
              8'h68, 8'h69, 8'h6A, 8'h6B, 8'h6C, 8'h6D, 8'hE5};
    for (int k = 0; k < 15; k++) wr(bytes[k]);
    // R13 fields visible right after the capturing edge
    chk("R13", "scroll", int'(scroll), 5);
    chk("R13", "dbl1", int'(dbl1), 3);
    chk("R4", "eq_const", int'(eq_const), 11);
    chk("R5", "hsync_w", int'(hsync_w), 24);
    chk("R5", "hbp", int'(hbp), 11);
    chk("R6", "vfp", int'(vfp), 24);
    chk("R6", "vbp", int'(vbp), 22);
    chk("R7", "rows", int'(rows), 50);
    chk("R7", "cpr", int'(cpr), 80);
    chk("R10", "misc_regs", int'(misc_regs[7:0]), 8'h66);
    idle();
    chk("R12", "hfp", int'(hfp), 3);

    // R2 saturation at register 14
    wr(8'h17);
    wr(8'h28);
    chk("R2", "scroll", int'(scroll), 8);
    chk("R2", "dbl2", int'(dbl2), 2);

    // R3 set pointer
    cmd(8'h15);
    wr(8'hFF);
    chk("R3", "cpr", int'(cpr), 256);
    wr(8'h01);
    chk("R2", "misc_regs", int'(misc_regs[7:0]), 1);

    // R3 master reset keeps contents
    cmd(8'h00);
    wr(8'h80);
    chk("R3", "dbl_en", int'(dbl_en), 1);
    chk("R3", "cpr", int'(cpr), 256);

    // R9 override with double size on, then off
    drv(0, 8'h00, 0, 8'h00, 1, 8'hC7);
    chk("R9", "dbl1", int'(dbl1), 3);
    chk("R9", "ss1_addr_hi", int'(ss1_addr_hi), 7);
    cmd(8'h10);
    wr(8'h00);
    drv(0, 8'h00, 0, 8'h00, 1, 8'h8A);
    chk("R9", "dbl1", int'(dbl1), 3);
    chk("R9", "ss1_addr_hi", int'(ss1_addr_hi), 10);

    // R11 write at pointer 15 ignored, pointer then 14
    cmd(8'h1F);
    wr(8'h55);
    chk("R11", "misc_regs", int'(misc_regs[7:0]), 1);
    chk("R11", "scroll", int'(scroll), 8);
    wr(8'h03);
    chk("R11", "scroll", int'(scroll), 3);

    // R3 command colliding with a write; unknown command ignored
    drv(1, 8'h77, 1, 8'h13, 0, 8'h00);
    chk("R3", "scroll", int'(scroll), 7);
    wr(8'h00);
    chk("R3", "vfp", int'(vfp), 4);
    drv(1, 8'hE0, 1, 8'h2A, 0, 8'h00);
    chk("R3", "rows", int'(rows), 97);

    // Random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      bit w, c, s;
      logic [7:0] cd;
      int sel;
      w = ($urandom % 2) == 0;
      c = ($urandom % 8) == 0;
      s = ($urandom % 8) == 0;
      sel = $urandom % 4;
      cd = (sel == 0) ? 8'h00 : (sel == 1) ? 8'h2F : {4'h1, 4'($urandom)};
      if (($urandom % 200) == 0) rst = 1'b1;
      drv(w, 8'($urandom), c, cd, s, 8'($urandom));
      rst = 1'b0;
    end
    idle();
    idle();
    summary();
  end
endmodule